// File: doc/BRIEF.md
# UART Receive Error Interrupt Controller

This block keeps the sticky receive status of an asynchronous serial receiver and turns it into two interrupt requests: one for receive errors and one for line breaks. A receiver core sends it one-cycle event pulses for a framing error, a parity error, a detected break and each received byte, together with a FIFO-full level. From these the block maintains six flags. A byte that arrives while the FIFO is full is dropped and recorded as an overrun.

Software reaches the block through a small register port with two registers, status and control. The control register holds the receive enable and two interrupt enables. Either enable alone is enough to let the error and break requests through. A flag can be cleared only by first reading it as 1 and then writing 0 to it. Turning the receiver off does not disturb the flags. The block also gives the receiver a qualifier that allows a new reception to start.

Top module: `uart_rxerr_irq`

## Requirements
- R1: `rx_start_o` is combinational. It equals receive-enable AND the trigger, where the trigger is `start_det_i` when `sync_mode_i` is 0 and `sync_edge_i` when it is 1.
- R2: Writing receive-enable to 0 leaves every status flag unchanged.
- R3: Each interrupt request is a register that takes, one clock later, its flag condition ANDed with (rie OR reie). For `err_irq_o` the flag condition is the ERR flag OR the OVR flag. For `brk_irq_o` it is the BRK flag.
- R4: With reie=1 and rie=0, a set flag still raises its request.
- R5: When rie and reie are both 0, both requests are 0 from one clock after the control write.
- R6: Control register (`reg_sel_i`=1) bit layout: bit0 is receive-enable, bit1 is rie, bit2 is reie. Bit 3 is reserved, and it and all higher bits read 0 whatever value is written.
- R7: After reset the control bits, all flags and both requests are 0.
- R8: Writing 0 to a flag bit clears it only if a status read since the flag last became set returned that bit as 1. Writing 1, or writing 0 without such a read, leaves the flag set.
- R9: An event that sets a flag wins over a clearing write in the same cycle, and the flag stays set.
- R10: A `rx_byte_i` pulse with `fifo_full_i`=1 sets OVR and leaves DR alone. With `fifo_full_i`=0 it sets DR.
- R11: Status register (`reg_sel_i`=0) bit layout: bit0 DR, bit1 FRM, bit2 PAR, bit3 BRK, bit4 ERR, bit5 OVR. A framing pulse sets FRM and ERR, a parity pulse sets PAR and ERR, and a break pulse sets BRK. Each flag updates one clock after its pulse.
- R12: `reg_rdata_o` is combinational. It shows the status flags when `reg_sel_i`=0 and the control bits when `reg_sel_i`=1, with all unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_i | input | 1 | A byte was received |
| fifo_full_i | input | 1 | Receive FIFO full level |
| frame_err_i | input | 1 | Framing error pulse |
| parity_err_i | input | 1 | Parity error pulse |
| break_i | input | 1 | Break detected pulse |
| start_det_i | input | 1 | Start bit detected (asynchronous mode) |
| sync_edge_i | input | 1 | Synchronisation clock edge (clocked mode) |
| sync_mode_i | input | 1 | 1 selects clocked synchronous mode |
| reg_sel_i | input | 1 | 0 selects status, 1 selects control |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| flags_o | output | 6 | Sticky status flags |
| rx_start_o | output | 1 | Reception start qualifier |
| err_irq_o | output | 1 | Receive-error interrupt request |
| brk_irq_o | output | 1 | Break interrupt request |

## Verification
Two functions can fall in the same cycle: setting a flag from a receiver event and clearing that flag through the read-then-write handshake. A directed case arms FRM with a read, then issues a zero write in the very cycle a new framing pulse arrives; after that edge FRM must still be set. Random stimulus then mixes events, reads and writes at high rates so that such coincidences recur on every flag. Each outcome is judged against a bench model that applies set-over-clear priority.

// File: rtl/uart_rxerr_pkg.sv
package uart_rxerr_pkg;
    localparam int NFLAG = 6;
    localparam int F_DR  = 0;
    localparam int F_FRM = 1;
    localparam int F_PAR = 2;
    localparam int F_BRK = 3;
    localparam int F_ERR = 4;
    localparam int F_OVR = 5;
    localparam int NCTRL = 3;

    typedef struct packed {
        logic reie;
        logic rie;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    typedef struct packed {
        logic eri;
        logic bri;
    } irq_t;
endpackage

// File: rtl/rxerr_flag_bank.sv
module rxerr_flag_bank #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [NF-1:0] wdata_i,
    output logic [NF-1:0] flags_o
);
    import uart_rxerr_pkg::*;

    for (genvar g = 0; g < NF; g++) begin : g_cell
        cell_t c_d, c_q;
        logic  clr;

        always_comb begin
            c_d     = c_q;
            clr     = wr_i & ~wdata_i[g] & c_q.armed & c_q.flag;
            c_d.flag  = set_i[g] | (c_q.flag & ~clr);
            // a read seeing the flag at 1 arms the clearing write
            c_d.armed = c_d.flag & ~clr & (c_q.armed | (rd_i & c_q.flag));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign flags_o[g] = c_q.flag;
    end
endmodule

// File: rtl/rxerr_ctrl_reg.sv
module rxerr_ctrl_reg
    import uart_rxerr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [NCTRL-1:0] wdata_i,
    output ctrl_t            ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) ctrl_d = ctrl_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rxerr_irq_gen.sv
module rxerr_irq_gen
    import uart_rxerr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_src_i,
    input  logic brk_src_i,
    input  logic rie_i,
    input  logic reie_i,
    output logic eri_o,
    output logic bri_o
);
    irq_t irq_d, irq_q;
    logic gate;

    always_comb begin
        gate      = rie_i | reie_i;
        irq_d.eri = err_src_i & gate;
        irq_d.bri = brk_src_i & gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign eri_o = irq_q.eri;
    assign bri_o = irq_q.bri;
endmodule

// File: rtl/uart_rxerr_irq.sv
module uart_rxerr_irq
    import uart_rxerr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_i,
    input  logic              fifo_full_i,
    input  logic              frame_err_i,
    input  logic              parity_err_i,
    input  logic              break_i,
    input  logic              start_det_i,
    input  logic              sync_edge_i,
    input  logic              sync_mode_i,
    input  logic              reg_sel_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [NFLAG-1:0]  flags_o,
    output logic              rx_start_o,
    output logic              err_irq_o,
    output logic              brk_irq_o
);
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    ctrl_t            ctrl;
    logic             stat_wr, stat_rd, ctrl_wr;
    logic             en_w, rie_w, reie_w;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata_i[DATA_W-1:NFLAG];

    always_comb begin
        stat_wr = reg_wr_i & ~reg_sel_i;
        stat_rd = reg_rd_i & ~reg_sel_i;
        ctrl_wr = reg_wr_i &  reg_sel_i;
        set_vec        = '0;
        set_vec[F_DR]  = rx_byte_i & ~fifo_full_i;
        set_vec[F_OVR] = rx_byte_i &  fifo_full_i;
        set_vec[F_FRM] = frame_err_i;
        set_vec[F_PAR] = parity_err_i;
        set_vec[F_ERR] = frame_err_i | parity_err_i;
        set_vec[F_BRK] = break_i;
    end

    rxerr_flag_bank #(.NF(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .rd_i    (stat_rd),
        .wr_i    (stat_wr),
        .wdata_i (reg_wdata_i[NFLAG-1:0]),
        .flags_o (flags)
    );

    rxerr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr),
        .wdata_i (reg_wdata_i[NCTRL-1:0]),
        .ctrl_o  (ctrl)
    );

    assign en_w   = ctrl.en;
    assign rie_w  = ctrl.rie;
    assign reie_w = ctrl.reie;

    rxerr_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_src_i (flags[F_ERR] | flags[F_OVR]),
        .brk_src_i (flags[F_BRK]),
        .rie_i     (rie_w),
        .reie_i    (reie_w),
        .eri_o     (err_irq_o),
        .bri_o     (brk_irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_sel_i) reg_rdata_o[NCTRL-1:0] = ctrl;
        else           reg_rdata_o[NFLAG-1:0] = flags;
        rx_start_o = en_w & (sync_mode_i ? sync_edge_i : start_det_i);
    end

    assign flags_o = flags;
endmodule

// File: rtl/uart_rxerr_irq_chk.sv
module uart_rxerr_irq_chk
    import uart_rxerr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_byte_i,
    input logic              fifo_full_i,
    input logic              frame_err_i,
    input logic              parity_err_i,
    input logic              break_i,
    input logic              reg_sel_i,
    input logic              reg_wr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic [NFLAG-1:0]  flags_o,
    input logic              rx_start_o,
    input logic              err_irq_o,
    input logic              brk_irq_o,
    input logic              en,
    input logic              rie,
    input logic              reie
);
    p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !rx_start_o);

    p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_byte_i && !frame_err_i && !parity_err_i && !break_i && !(reg_wr_i && !reg_sel_i))
        |=> $stable(flags_o));

    p_eri_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o[F_ERR] || flags_o[F_OVR]) && rie) |=> err_irq_o);

    p_reie_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[F_BRK] && reie && !rie) |=> brk_irq_o);

    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rie && !reie) |=> (!err_irq_o && !brk_irq_o));

    p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_i |-> (reg_rdata_o[DATA_W-1:NCTRL] == '0));

    p_one_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i && reg_wdata_i[F_ERR] && flags_o[F_ERR]) |=> flags_o[F_ERR]);

    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_i |=> (flags_o[F_FRM] && flags_o[F_ERR]));

    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_i && fifo_full_i) |=> flags_o[F_OVR]);
endmodule

bind uart_rxerr_irq uart_rxerr_irq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte_i    (rx_byte_i),
    .fifo_full_i  (fifo_full_i),
    .frame_err_i  (frame_err_i),
    .parity_err_i (parity_err_i),
    .break_i      (break_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .flags_o      (flags_o),
    .rx_start_o   (rx_start_o),
    .err_irq_o    (err_irq_o),
    .brk_irq_o    (brk_irq_o),
    .en           (en_w),
    .rie          (rie_w),
    .reie         (reie_w)
);

// File: tb/uart_rxerr_irq_bench.sv
module uart_rxerr_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic rx_byte, fifo_full, frame_err, parity_err, brk_ev;
    logic start_det, sync_edge, sync_mode;
    logic reg_sel, reg_rd, reg_wr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic [5:0] flags;
    logic rx_start, err_irq, brk_irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [5:0] m_flags, m_armed;
    logic [2:0] m_ctrl;
    logic       m_eri, m_bri;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rxerr_irq #(.DATA_W(DW)) u_uart_rxerr_irq (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_i(rx_byte), .fifo_full_i(fifo_full),
        .frame_err_i(frame_err), .parity_err_i(parity_err), .break_i(brk_ev),
        .start_det_i(start_det), .sync_edge_i(sync_edge), .sync_mode_i(sync_mode),
        .reg_sel_i(reg_sel), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .flags_o(flags), .rx_start_o(rx_start),
        .err_irq_o(err_irq), .brk_irq_o(brk_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        return reg_sel ? {5'b0, m_ctrl} : {2'b0, m_flags};
    endfunction

    function automatic logic exp_start();
        return m_ctrl[0] & (sync_mode ? sync_edge : start_det);
    endfunction

    function automatic logic [5:0] exp_set();
        logic [5:0] s;
        s[0] = rx_byte & ~fifo_full;
        s[1] = frame_err;
        s[2] = parity_err;
        s[3] = brk_ev;
        s[4] = frame_err | parity_err;
        s[5] = rx_byte & fifo_full;
        return s;
    endfunction

    task automatic idle();
        rx_byte = 0; frame_err = 0; parity_err = 0; brk_ev = 0;
        reg_rd = 0; reg_wr = 0; start_det = 0; sync_edge = 0;
    endtask

    // called at a negedge with inputs already driven
    task automatic step();
        logic [5:0] s, nf, na;
        logic [2:0] nc;
        logic ne, nb, gate;
        #1;
        chk("R12 rdata", reg_rdata, exp_rdata());
        chk("R1 rx_start", {7'b0, rx_start}, {7'b0, exp_start()});
        s = exp_set();
        for (int i = 0; i < 6; i++) begin
            logic clr;
            clr = reg_wr & ~reg_sel & ~reg_wdata[i] & m_armed[i] & m_flags[i];
            nf[i] = s[i] | (m_flags[i] & ~clr);
            na[i] = nf[i] & ~clr & (m_armed[i] | (reg_rd & ~reg_sel & m_flags[i]));
        end
        nc = (reg_wr & reg_sel) ? reg_wdata[2:0] : m_ctrl;
        gate = m_ctrl[1] | m_ctrl[2];
        ne = (m_flags[4] | m_flags[5]) & gate;
        nb = m_flags[3] & gate;
        @(posedge clk);
        m_flags = nf; m_armed = na; m_ctrl = nc; m_eri = ne; m_bri = nb;
        @(negedge clk);
        chk("R11 flags", {2'b0, flags}, {2'b0, m_flags});
        chk("R3 err_irq", {7'b0, err_irq}, {7'b0, m_eri});
        chk("R3 brk_irq", {7'b0, brk_irq}, {7'b0, m_bri});
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        idle(); reg_sel = sel; reg_wr = 1; reg_wdata = d; step(); idle();
    endtask

    task automatic rd_stat();
        idle(); reg_sel = 0; reg_rd = 1; step(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; idle(); fifo_full = 0; sync_mode = 0; reg_sel = 1; reg_wdata = '0;
        m_flags = 0; m_armed = 0; m_ctrl = 0; m_eri = 0; m_bri = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset ctrl", reg_rdata, 8'h00);
        chk("R7 reset flags", {2'b0, flags}, 8'h00);
        chk("R7 reset irq", {6'b0, err_irq, brk_irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R6: reserved and upper control bits read 0
        wr_reg(1, 8'hFF);
        reg_sel = 1; #1;
        chk("R6 reserved bits", reg_rdata, 8'h07);

        // R1: start qualifier in both modes
        sync_mode = 0; start_det = 1; #1;
        chk("R1 async start", {7'b0, rx_start}, 8'h01);
        sync_mode = 1; #1;
        chk("R1 sync ignores start bit", {7'b0, rx_start}, 8'h00);
        sync_edge = 1; #1;
        chk("R1 sync edge start", {7'b0, rx_start}, 8'h01);
        idle(); sync_mode = 0;

        // R4: reie alone raises break request
        wr_reg(1, 8'h05);
        brk_ev = 1; step(); idle();
        step();
        chk("R4 reie only break irq", {7'b0, brk_irq}, 8'h01);

        // R5: both enables off removes requests
        wr_reg(1, 8'h01);
        step();
        chk("R5 irq removed", {6'b0, err_irq, brk_irq}, 8'h00);

        // R2: receiver off keeps flags
        wr_reg(1, 8'h00);
        chk("R2 brk kept", {7'b0, flags[3]}, 8'h01);

        // R8: zero write without read keeps, with read clears
        wr_reg(0, 8'h00);
        chk("R8 no read no clear", {7'b0, flags[3]}, 8'h01);
        rd_stat();
        wr_reg(0, 8'h08);
        chk("R8 write one keeps", {7'b0, flags[3]}, 8'h01);
        wr_reg(0, 8'h00);
        chk("R8 handshake clears", {7'b0, flags[3]}, 8'h00);

        // R9: event beats clearing write
        frame_err = 1; step(); idle();
        rd_stat();
        reg_sel = 0; reg_wr = 1; reg_wdata = 8'h00; frame_err = 1; step(); idle();
        chk("R9 event wins", {6'b0, flags[4], flags[1]}, 8'h03);

        // R10: overrun on full FIFO, data-ready otherwise
        rd_stat(); wr_reg(0, 8'h00);
        fifo_full = 1; rx_byte = 1; step(); idle(); fifo_full = 0;
        chk("R10 ovr set dr clear", {6'b0, flags[5], flags[0]}, 8'h02);
        rx_byte = 1; step(); idle();
        chk("R10 dr set", {7'b0, flags[0]}, 8'h01);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            rx_byte    = ($urandom % 8) == 0;
            fifo_full  = ($urandom % 3) == 0;
            frame_err  = ($urandom % 10) == 0;
            parity_err = ($urandom % 10) == 0;
            brk_ev     = ($urandom % 12) == 0;
            start_det  = r[0];
            sync_edge  = r[1];
            sync_mode  = r[2];
            reg_sel    = ($urandom % 4) == 0;
            reg_rd     = ($urandom % 2) == 0;
            reg_wr     = ($urandom % 3) == 0;
            reg_wdata  = 8'($urandom);
            step();
        end
        idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule